// File: doc/BRIEF.md
# Polled Serial Host Link Port

This block gives a CPU a byte pipe to a remote disk server over an asynchronous serial line, using only two bus addresses. The CPU polls one status address to learn whether an incoming byte is waiting, and it uses a single data address both to take the oldest received byte and to hand over a byte for sending. Incoming bytes collect in a small receive queue. Outgoing bytes wait in a transmit queue in front of the shifter, so the CPU can write a burst without any handshake.

The serial line runs at one of four fixed rates picked by a two-bit select input. The receiver oversamples the line at sixteen times the bit rate and finds the middle of each bit from the start-bit edge. The only status the CPU sees is the "byte waiting" flag. A sticky debug output records that a write was lost to a full transmit queue.

Top module: `hostLinkPort`

## Requirements
- R1: While reset is held and just after it is released, `busRdData` is 0x00, `txPin` is high, `txOverflow` is 0 and a status read returns 0x00.
- R2: A read of the status address (default 0xFF41) returns bit 1 = 1 exactly when at least one received byte is waiting; bits 7..2 and bit 0 always read 0. Read data appears on `busRdData` one clock after the cycle in which `busRd` is high, and it stays there until the next read.
- R3: A read of the data address (default 0xFF42) returns the oldest waiting received byte and removes it, so the bytes come out in arrival order.
- R4: A read of the data address when no byte is waiting leaves `busRdData` at its previous value and removes nothing.
- R5: Each byte written to the data address is sent on `txPin` as one low start bit, eight data bits LSB first and one high stop bit. The line idles high between frames, and bytes go out in write order.
- R6: Each bit lasts 16*D clocks, where D = (CLK_HZ + 8*B) / (16*B) in integer arithmetic, and B is 115200, 230400, 460800 or 921600 bit/s for `rateSel` = 00, 01, 10 or 11.
- R7: Up to TX_DEPTH (default 16) bytes wait behind the byte being shifted. A write that finds the queue full is dropped and sets `txOverflow`, which stays set until reset.
- R8: A byte received while RX_DEPTH (default 4) bytes are already waiting is discarded, and the bytes already waiting are kept.
- R9: Writes to the status address or to any unmapped address send nothing. Reads of an unmapped address return 0x00.
- R10: A received frame is accepted only if the line is still low half a bit time after the start edge and the stop bit is sampled high, so a low pulse shorter than half a bit yields no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | CPU address |
| busWrData | input | 8 | CPU write byte |
| busRd | input | 1 | One-cycle read strobe |
| busWr | input | 1 | One-cycle write strobe |
| busRdData | output | 8 | Registered read result |
| rateSel | input | 2 | Line rate select |
| rxPin | input | 1 | Serial input, idles high |
| txPin | output | 1 | Serial output, idles high |
| txOverflow | output | 1 | Sticky flag: a transmit write was dropped |

## Verification
The assertions assume that each bus strobe lasts one cycle, that `busRd` and `busWr` are never high together, and that `rateSel` changes only while the line is idle in both directions. The stimulus meets these assumptions by driving every access through a task that raises a single strobe for one clock. It changes the rate only after the transmit scoreboard has drained and no receive frame is in flight. Received frames are driven at exactly the nominal bit period, so the oversampling margin is never tested beyond one divider step.

// File: rtl/hlpPkg.sv
package hlpPkg;

  // position of the "byte waiting" flag in the status word
  localparam int READY_BIT = 1;
  localparam int BASE_BAUD = 115200;

  typedef struct packed {
    logic pushTx;
    logic popRx;
    logic rdStatus;
    logic rdOther;
  } hlpStrobes_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  // rounded clocks per oversample tick for a given bit rate
  function automatic int unsigned divFor(int unsigned clkHz, int unsigned baud);
    return (clkHz + baud * 8) / (baud * 16);
  endfunction

endpackage

// File: rtl/hlpFifo.sv
module hlpFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hlpControl.sv
module hlpControl #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'hFF41,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'hFF42
) (
  input  logic              [ADDR_W-1:0] busAddr,
  input  logic                           busRd,
  input  logic                           busWr,
  output hlpPkg::hlpStrobes_t            strb
);
  logic hitStatus, hitData;

  assign hitStatus = (busAddr == STATUS_ADDR);
  assign hitData   = (busAddr == DATA_ADDR);

  always_comb begin
    strb          = '0;
    strb.pushTx   = busWr && hitData;
    strb.popRx    = busRd && hitData;
    strb.rdStatus = busRd && hitStatus;
    strb.rdOther  = busRd && !hitStatus && !hitData;
  end
endmodule

// File: rtl/hlpDatapath.sv
module hlpDatapath #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  hlpPkg::hlpStrobes_t strb,
  input  logic [7:0]          wrByte,
  input  logic [1:0]          rateSel,
  input  logic                rxPin,
  output logic                txPin,
  output logic [7:0]          rdData,
  output logic                txOverflow,
  output logic                rxHasData,
  output logic                txFull,
  output logic                txBusy
);
  import hlpPkg::*;

  localparam int unsigned DIV0  = divFor(CLK_HZ, BASE_BAUD);
  localparam int unsigned DIV1  = divFor(CLK_HZ, BASE_BAUD * 2);
  localparam int unsigned DIV2  = divFor(CLK_HZ, BASE_BAUD * 4);
  localparam int unsigned DIV3  = divFor(CLK_HZ, BASE_BAUD * 8);
  localparam int          CNT_W = $clog2(DIV0 + 1);

  // ---------------- oversample tick ----------------
  logic [CNT_W-1:0] divLast, divCnt;
  logic tick;

  always_comb begin
    case (rateSel)
      2'd0:    divLast = CNT_W'(DIV0 - 1);
      2'd1:    divLast = CNT_W'(DIV1 - 1);
      2'd2:    divLast = CNT_W'(DIV2 - 1);
      default: divLast = CNT_W'(DIV3 - 1);
    endcase
  end

  assign tick = (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // ---------------- transmit path ----------------
  logic [7:0] txHead;
  logic       txEmpty, txPop;
  logic [9:0] txShift;
  logic [3:0] txTicks, txBitsLeft;

  assign txPop = !txBusy && tick && !txEmpty;

  hlpFifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN), .push(strb.pushTx), .pop(txPop),
    .din(wrByte), .head(txHead), .empty(txEmpty), .full(txFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txShift    <= '1;
      txTicks    <= '0;
      txBitsLeft <= '0;
    end else if (!txBusy) begin
      if (txPop) begin
        txShift    <= {1'b1, txHead, 1'b0};
        txBusy     <= 1'b1;
        txTicks    <= '0;
        txBitsLeft <= 4'd10;
      end
    end else if (tick) begin
      if (txTicks == 4'd15) begin
        txTicks    <= '0;
        txShift    <= {1'b1, txShift[9:1]};
        txBitsLeft <= txBitsLeft - 4'd1;
        if (txBitsLeft == 4'd1) txBusy <= 1'b0;
      end else begin
        txTicks <= txTicks + 4'd1;
      end
    end
  end

  assign txPin = txBusy ? txShift[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        txOverflow <= 1'b0;
    else if (strb.pushTx && txFull)   txOverflow <= 1'b1;
  end

  // ---------------- receive path ----------------
  logic [1:0] rxSyncPipe;
  logic       rxSync;
  rxState_t   rxState;
  logic [3:0] rxTicks;
  logic [2:0] rxBit;
  logic [7:0] rxShift, rxHead;
  logic       rxPush, rxEmpty, rxFull;

  assign rxSync = rxSyncPipe[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSyncPipe <= 2'b11;
    else       rxSyncPipe <= {rxSyncPipe[0], rxPin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxPush  <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (tick) begin
        case (rxState)
          RX_IDLE: if (!rxSync) begin
            rxState <= RX_START;
            rxTicks <= '0;
          end
          RX_START: if (rxTicks == 4'd7) begin
            rxTicks <= '0;
            rxBit   <= '0;
            rxState <= rxSync ? RX_IDLE : RX_DATA;
          end else rxTicks <= rxTicks + 4'd1;
          RX_DATA: if (rxTicks == 4'd15) begin
            rxTicks <= '0;
            rxShift <= {rxSync, rxShift[7:1]};
            if (rxBit == 3'd7) rxState <= RX_STOP;
            else               rxBit   <= rxBit + 3'd1;
          end else rxTicks <= rxTicks + 4'd1;
          RX_STOP: if (rxTicks == 4'd15) begin
            rxTicks <= '0;
            rxState <= RX_IDLE;
            rxPush  <= rxSync;
          end else rxTicks <= rxTicks + 4'd1;
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  hlpFifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(strb.popRx),
    .din(rxShift), .head(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  assign rxHasData = !rxEmpty;

  // ---------------- read register ----------------
  logic [7:0] statusWord;

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = rxHasData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rdData <= '0;
    else if (strb.rdStatus)             rdData <= statusWord;
    else if (strb.popRx && rxHasData)   rdData <= rxHead;
    else if (strb.rdOther)              rdData <= '0;
  end

  logic unusedRx;
  assign unusedRx = rxFull;
endmodule

// File: rtl/hostLinkPort.sv
module hostLinkPort #(
  parameter int                CLK_HZ      = 100_000_000,
  parameter int                RX_DEPTH    = 4,
  parameter int                TX_DEPTH    = 16,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'hFF41,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'hFF42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [7:0]        busRdData,
  input  logic [1:0]        rateSel,
  input  logic              rxPin,
  output logic              txPin,
  output logic              txOverflow
);
  hlpPkg::hlpStrobes_t strb;
  logic rxHasData, txFull, txBusy;

  hlpControl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)) ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .strb(strb)
  );

  hlpDatapath #(.CLK_HZ(CLK_HZ), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(busWrData), .rateSel(rateSel),
    .rxPin(rxPin), .txPin(txPin), .rdData(busRdData), .txOverflow(txOverflow),
    .rxHasData(rxHasData), .txFull(txFull), .txBusy(txBusy)
  );
endmodule

// File: rtl/hlpChecker.sv
module hlpChecker #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'hFF41,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'hFF42
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [7:0]        busRdData,
  input logic              txPin,
  input logic              txOverflow,
  input logic              rxHasData,
  input logic              txFull,
  input logic              txBusy
);
  // R2
  status_unused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == STATUS_ADDR) |=> ((busRdData & 8'hFD) == 8'h00));

  // R2
  status_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == STATUS_ADDR) |=> (busRdData[1] == $past(rxHasData)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == DATA_ADDR && !rxHasData) |=> $stable(busRdData));

  // R5
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txPin);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> txOverflow);

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == DATA_ADDR && txFull) |=> txOverflow);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr != STATUS_ADDR && busAddr != DATA_ADDR) |=> (busRdData == 8'h00));
endmodule

bind hostLinkPort hlpChecker #(
  .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busRdData(busRdData), .txPin(txPin), .txOverflow(txOverflow),
  .rxHasData(rxHasData), .txFull(txFull), .txBusy(txBusy)
);

// File: tb/tb_hostLinkPort.sv
module tb_hostLinkPort;
  localparam int CLK_HZ = 100_000_000;
  localparam logic [15:0] ST = 16'hFF41;
  localparam logic [15:0] DT = 16'hFF42;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busRdData;
  logic [1:0] rateSel = 2'd3;
  logic rxPin = 1'b1;
  logic txPin, txOverflow;

  int compared = 0, mismatched = 0, txFrames = 0;
  logic [7:0] txExp[$];

  always #5 clk = ~clk;

  hostLinkPort dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData), .rateSel(rateSel),
    .rxPin(rxPin), .txPin(txPin), .txOverflow(txOverflow)
  );

  function automatic int bitCycles(logic [1:0] sel);
    int baud;
    baud = 115200 << sel;
    return 16 * ((CLK_HZ + baud * 8) / (baud * 16));
  endfunction

  task automatic check(string req, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic cpuWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic cpuRead(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  // driver: expected transmit bytes go to the scoreboard queue
  task automatic sendByte(logic [7:0] d);
    txExp.push_back(d);
    cpuWrite(DT, d);
  endtask

  task automatic drainTx();
    while (txExp.size() != 0) @(negedge clk);
    repeat (bitCycles(rateSel) * 2) @(negedge clk);
  endtask

  task automatic rxFrame(logic [7:0] d);
    int bc;
    bc = bitCycles(rateSel);
    rxPin = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxPin = d[i];
      repeat (bc) @(negedge clk);
    end
    rxPin = 1'b1;
    repeat (bc) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // monitor: decode the serial output and compare against the queue (R5 R6)
  initial begin
    logic [7:0] got;
    int bc;
    forever begin
      @(negedge txPin);
      bc = bitCycles(rateSel);
      repeat (bc / 2) @(negedge clk);
      check("R5 start bit", int'(txPin), 0);
      for (int i = 0; i < 8; i++) begin
        repeat (bc) @(negedge clk);
        got[i] = txPin;
      end
      repeat (bc) @(negedge clk);
      check("R5 stop bit", int'(txPin), 1);
      txFrames++;
      if (txExp.size() == 0) check("R9 unexpected frame", int'(got), -1);
      else check("R6 R5 tx byte", int'(got), int'(txExp.pop_front()));
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog all R actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int frames0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 rdData in reset", int'(busRdData), 0);
    check("R1 txPin in reset", int'(txPin), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 overflow after reset", int'(txOverflow), 0);
    cpuRead(ST, d);
    check("R1 status after reset", int'(d), 0);

    // R5 at the fastest rate, two bytes back to back
    sendByte(8'hA5);
    sendByte(8'h3C);
    drainTx();

    // R6 other rates
    rateSel = 2'd0; sendByte(8'h81); drainTx();
    rateSel = 2'd1; sendByte(8'h5A); drainTx();
    rateSel = 2'd2; sendByte(8'h0F); drainTx();
    rateSel = 2'd3;
    check("R6 frames sent", txFrames, 5);

    // R2 R3 single receive
    rxFrame(8'h11);
    cpuRead(ST, d); check("R2 status waiting", int'(d), 8'h02);
    cpuRead(DT, d); check("R3 rx byte", int'(d), 8'h11);
    cpuRead(ST, d); check("R2 status empty", int'(d), 8'h00);

    // R3 order
    rxFrame(8'h21); rxFrame(8'h32); rxFrame(8'h43);
    cpuRead(DT, d); check("R3 order 0", int'(d), 8'h21);
    cpuRead(DT, d); check("R3 order 1", int'(d), 8'h32);
    cpuRead(DT, d); check("R3 order 2", int'(d), 8'h43);

    // R4 empty read
    cpuRead(DT, d); check("R4 empty read holds", int'(d), 8'h43);
    cpuRead(ST, d); check("R4 status still empty", int'(d), 8'h00);

    // R8 receive queue full
    for (int i = 0; i < 5; i++) rxFrame(8'(8'h50 + i));
    cpuRead(ST, d); check("R8 status full", int'(d), 8'h02);
    for (int i = 0; i < 4; i++) begin
      cpuRead(DT, d); check("R8 kept byte", int'(d), 8'h50 + i);
    end
    cpuRead(ST, d); check("R8 fifth discarded", int'(d), 8'h00);

    // R9 ignored writes and unmapped reads
    frames0 = txFrames;
    cpuWrite(ST, 8'hFF);
    cpuWrite(16'h1234, 8'h77);
    repeat (bitCycles(rateSel) * 12) @(negedge clk);
    check("R9 no frame from stray write", txFrames, frames0);
    cpuRead(ST, d); check("R9 status unchanged", int'(d), 8'h00);
    cpuRead(16'h1234, d); check("R9 unmapped read", int'(d), 8'h00);
    cpuRead(16'hFF40, d); check("R9 neighbour read", int'(d), 8'h00);

    // R10 short glitch is rejected, then a real frame is taken
    rxPin = 1'b0;
    repeat (bitCycles(rateSel) / 4) @(negedge clk);
    rxPin = 1'b1;
    repeat (bitCycles(rateSel) * 12) @(negedge clk);
    cpuRead(ST, d); check("R10 glitch ignored", int'(d), 8'h00);
    rxFrame(8'h6E);
    cpuRead(DT, d); check("R10 frame after glitch", int'(d), 8'h6E);

    // R7 transmit overflow
    frames0 = txFrames;
    check("R7 overflow clear before", int'(txOverflow), 0);
    for (int i = 0; i < 20; i++) begin
      if (i < 17) sendByte(8'(8'h80 + i));
      else cpuWrite(DT, 8'(8'h80 + i));
    end
    check("R7 overflow set", int'(txOverflow), 1);
    drainTx();
    check("R7 accepted count", txFrames - frames0, 17);
    check("R7 overflow sticky", int'(txOverflow), 1);

    finishRun();
  end
endmodule